// File: doc/BRIEF.md
# DS3 Transmit Overhead Inserter with One-Shot Error Injection

This block sits in the transmit path of a DS3 framer, just before line coding. It takes a serial stream with one bit per clock and a frame marker. It places the overhead bit at the head of every 85-bit block: the frame alignment bits, the multiframe alignment bits, the X bits, the two P bits and the C bits. The 84 payload bits that follow each overhead bit pass through unchanged. An M-frame holds 7 subframes of 8 blocks, so it is 4760 bits long. The block keeps its own position count. A frame marker forces the bit that carries it to be bit 0 of a new M-frame.

The P bits carry the parity of the payload of the previous M-frame. In C-bit parity mode, the block also fills the three C bits of subframe 3 with that parity. It fills the three C bits of subframe 4 with the far-end block error (FEBE) indication. Every other C bit comes from the input stream at its own position. In M13 mode, all C bits come from the input stream.

Four active-low force pins allow single-error testing. They can corrupt one overhead bit, invert both P bits, invert the subframe-3 parity C bits, or send one FEBE. Each request acts once, at the next place where its target occurs.

Top module: `ds3oi_top`

## Requirements
- R1: The bit presented on `tx_data` at a payload position (block bit 1..84) appears on `line_bit` one clock later. `line_ovh` is high exactly on the output cycle of a block bit 0. `line_fp` is high exactly on the output cycle of M-frame bit 0.
- R2: Within each subframe (blocks 0..7), the overhead bits of blocks 1, 3, 5 and 7 are sent as 1, 0, 0, 1. The block-0 overhead bits of subframes 5, 6 and 7 are sent as 0, 1, 0. The block-0 overhead bits of subframes 1 and 2 are sent as 1.
- R3: The block-0 overhead bits of subframes 3 and 4 (the P bits) are equal. They are 1 when the payload bits of the preceding M-frame hold an odd number of ones, and 0 otherwise. Both are 0 in the first frame after reset.
- R4: The C bits are the overhead bits of blocks 2, 4 and 6. In C-bit parity mode (`cbit_mode`=1), the subframe-3 C bits equal the P value and the subframe-4 C bits are 1. All other C bits, and every C bit in M13 mode, take the `tx_data` value at their own position.
- R5: A falling edge on `force_p_n` inverts both P bits of the next P pair whose first bit comes after the edge.
- R6: A falling edge on `force_oe_n` while `ovh_en` is high inverts the next overhead bit after the edge. With `ovh_en` low, the edge has no effect.
- R7: In C-bit parity mode, a falling edge on `force_cp_n` inverts the three subframe-3 C bits of the next frame in which they all follow the edge. In M13 mode, the edge has no effect.
- R8: In C-bit parity mode, a falling edge on `force_febe_n` sends the three subframe-4 C bits of the next such frame as 000. In M13 mode, the edge has no effect.
- R9: Each force produces exactly one error per falling edge. Holding a force pin low produces no further errors.
- R10: While `rst` is high, `line_bit`, `line_fp` and `line_ovh` are 0.
- R11: The bit presented with `frm_sync` high is treated as M-frame bit 0, and `line_fp` rises on the next cycle. Counting continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_sync | input | 1 | Marks the current input bit as M-frame bit 0 |
| tx_data | input | 1 | Serial payload and external C-bit stream |
| cbit_mode | input | 1 | 1 selects C-bit parity mode, 0 selects M13 mode |
| ovh_en | input | 1 | Enables the overhead-bit error request |
| force_oe_n | input | 1 | Overhead-bit error request, falling edge active |
| force_p_n | input | 1 | P-bit error request, falling edge active |
| force_cp_n | input | 1 | C-bit parity error request, falling edge active |
| force_febe_n | input | 1 | FEBE request, falling edge active |
| line_bit | output | 1 | Serial DS3 output |
| line_fp | output | 1 | High on the output cycle of M-frame bit 0 |
| line_ovh | output | 1 | High on the output cycle of an overhead bit |

## Verification
The assertions assume that `cbit_mode` changes only at M-frame boundaries, while no parity or FEBE corruption is in progress. They also assume that `frm_sync` is low while reset is applied. The stimulus switches mode only at the first bit of a new M-frame, after the subframe-3 and subframe-4 C bits of the previous frame have left. It raises `frm_sync` only after reset is released. Force pulses are random in start and length. Each pulse stays low for at least one bit, so every request is a clean single falling edge.

// File: rtl/ds3oi_pkg.sv
package ds3oi_pkg;
  // index of each force request in the request vectors
  localparam int FI_OE   = 0;
  localparam int FI_P    = 1;
  localparam int FI_CP   = 2;
  localparam int FI_FEBE = 3;
  localparam int NUM_FORCE = 4;

  // subframe indices (zero based) that carry special overhead
  localparam int SF_P1   = 2;
  localparam int SF_P2   = 3;
  localparam int SF_MHI  = 5;
  localparam int SF_MLO  = 4;

  // block index of the first C bit in a subframe
  localparam int BLK_C1  = 2;
endpackage

// File: rtl/ds3oi_position.sv
module ds3oi_position #(
  parameter int BLK_BITS = 85,
  parameter int BLKS     = 8,
  parameter int SUBFRMS  = 7,
  localparam int BW = $clog2(BLK_BITS),
  localparam int KW = $clog2(BLKS),
  localparam int SW = $clog2(SUBFRMS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_sync,
  output logic [BW-1:0] bit_idx,
  output logic [KW-1:0] blk_idx,
  output logic [SW-1:0] sf_idx,
  output logic          frame_start,
  output logic          is_ovh
);
  localparam logic [BW-1:0] LAST_BIT = BW'(BLK_BITS - 1);
  localparam logic [KW-1:0] LAST_BLK = KW'(BLKS - 1);
  localparam logic [SW-1:0] LAST_SF  = SW'(SUBFRMS - 1);

  logic [BW-1:0] bit_q, bit_n;
  logic [KW-1:0] blk_q, blk_n;
  logic [SW-1:0] sf_q,  sf_n;

  // position of the bit on the input this cycle
  always_comb begin
    if (frm_sync) begin
      bit_idx = '0;
      blk_idx = '0;
      sf_idx  = '0;
    end else begin
      bit_idx = bit_q;
      blk_idx = blk_q;
      sf_idx  = sf_q;
    end
  end

  assign is_ovh      = (bit_idx == '0);
  assign frame_start = is_ovh && (blk_idx == '0) && (sf_idx == '0);

  // position of the following bit
  always_comb begin
    bit_n = bit_idx + BW'(1);
    blk_n = blk_idx;
    sf_n  = sf_idx;
    if (bit_idx == LAST_BIT) begin
      bit_n = '0;
      blk_n = blk_idx + KW'(1);
      if (blk_idx == LAST_BLK) begin
        blk_n = '0;
        sf_n  = (sf_idx == LAST_SF) ? '0 : sf_idx + SW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
      blk_q <= '0;
      sf_q  <= '0;
    end else begin
      bit_q <= bit_n;
      blk_q <= blk_n;
      sf_q  <= sf_n;
    end
  end
endmodule

// File: rtl/ds3oi_parity.sv
module ds3oi_parity (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic pay_vld,
  input  logic din,
  output logic par_prev
);
  logic acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= 1'b0;
      par_prev <= 1'b0;
    end else if (frame_start) begin
      par_prev <= acc_q;
      acc_q    <= 1'b0;
    end else if (pay_vld) begin
      acc_q <= acc_q ^ din;
    end
  end
endmodule

// File: rtl/ds3oi_force_arm.sv
module ds3oi_force_arm (
  input  logic clk,
  input  logic rst,
  input  logic force_n,
  input  logic accept,
  input  logic cancel,
  input  logic consume,
  output logic fall,
  output logic armed
);
  logic prev_q;

  assign fall = prev_q & ~force_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      armed  <= 1'b0;
    end else begin
      prev_q <= force_n;
      if (cancel)              armed <= 1'b0;
      else if (fall && accept) armed <= 1'b1;
      else if (consume)        armed <= 1'b0;
    end
  end
endmodule

// File: rtl/ds3oi_top.sv
module ds3oi_top #(
  parameter int BLK_BITS = 85,
  parameter int BLKS     = 8,
  parameter int SUBFRMS  = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic frm_sync,
  input  logic tx_data,
  input  logic cbit_mode,
  input  logic ovh_en,
  input  logic force_oe_n,
  input  logic force_p_n,
  input  logic force_cp_n,
  input  logic force_febe_n,
  output logic line_bit,
  output logic line_fp,
  output logic line_ovh
);
  import ds3oi_pkg::*;

  localparam int BW = $clog2(BLK_BITS);
  localparam int KW = $clog2(BLKS);
  localparam int SW = $clog2(SUBFRMS);
  localparam logic [KW-1:0] BLK_LAST_C = KW'(BLKS - 2);

  logic [BW-1:0] bit_idx;
  logic [KW-1:0] blk_idx;
  logic [SW-1:0] sf_idx;
  logic          frame_start, is_ovh, par_prev;

  ds3oi_position #(.BLK_BITS(BLK_BITS), .BLKS(BLKS), .SUBFRMS(SUBFRMS)) pos_i (
    .clk(clk), .rst(rst), .frm_sync(frm_sync),
    .bit_idx(bit_idx), .blk_idx(blk_idx), .sf_idx(sf_idx),
    .frame_start(frame_start), .is_ovh(is_ovh)
  );

  ds3oi_parity par_i (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .pay_vld(!is_ovh), .din(tx_data), .par_prev(par_prev)
  );

  // overhead slot decode
  logic blk0, c_slot, c_first, c_last, sf_p1, sf_p2;
  logic p_slot1, p_slot2, cp_first, cp_slot, cp_last, fb_first, fb_slot, fb_last;

  assign blk0    = is_ovh && (blk_idx == '0);
  assign c_slot  = is_ovh && !blk_idx[0] && (blk_idx != '0);
  assign c_first = c_slot && (blk_idx == KW'(BLK_C1));
  assign c_last  = c_slot && (blk_idx == BLK_LAST_C);
  assign sf_p1   = (sf_idx == SW'(SF_P1));
  assign sf_p2   = (sf_idx == SW'(SF_P2));

  assign p_slot1  = blk0 && sf_p1;
  assign p_slot2  = blk0 && sf_p2;
  assign cp_slot  = cbit_mode && c_slot  && sf_p1;
  assign cp_first = cbit_mode && c_first && sf_p1;
  assign cp_last  = cbit_mode && c_last  && sf_p1;
  assign fb_slot  = cbit_mode && c_slot  && sf_p2;
  assign fb_first = cbit_mode && c_first && sf_p2;
  assign fb_last  = cbit_mode && c_last  && sf_p2;

  // force request arming
  logic [NUM_FORCE-1:0] force_n_v, accept_v, cancel_v, use_w, fall_w, arm_q;

  assign force_n_v = {force_febe_n, force_cp_n, force_p_n, force_oe_n};
  assign accept_v  = {cbit_mode, cbit_mode, 1'b1, ovh_en};
  assign cancel_v  = {!cbit_mode, !cbit_mode, 1'b0, 1'b0};
  assign use_w     = {fb_first, cp_first, p_slot1, is_ovh};

  for (genvar gi = 0; gi < NUM_FORCE; gi++) begin : g_arm
    ds3oi_force_arm arm_i (
      .clk(clk), .rst(rst), .force_n(force_n_v[gi]),
      .accept(accept_v[gi]), .cancel(cancel_v[gi]), .consume(use_w[gi]),
      .fall(fall_w[gi]), .armed(arm_q[gi])
    );
  end

  // multi-bit corruptions stay active for the rest of their field
  logic p_run, cp_run, fb_run;

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      p_run  <= 1'b0;
      cp_run <= 1'b0;
      fb_run <= 1'b0;
    end else begin
      if (p_slot1 && arm_q[FI_P])        p_run <= 1'b1;
      else if (p_slot2)                  p_run <= 1'b0;
      if (cp_first && arm_q[FI_CP])      cp_run <= 1'b1;
      else if (cp_last)                  cp_run <= 1'b0;
      if (fb_first && arm_q[FI_FEBE])    fb_run <= 1'b1;
      else if (fb_last)                  fb_run <= 1'b0;
    end
  end

  // nominal bit
  logic base_bit, flip;

  always_comb begin
    base_bit = tx_data;
    if (is_ovh) begin
      if (blk_idx[0]) begin
        base_bit = (blk_idx == KW'(1)) || (blk_idx == KW'(BLKS - 1));
      end else if (blk_idx == '0) begin
        if (sf_idx < SW'(SF_P1))       base_bit = 1'b1;
        else if (sf_idx <= SW'(SF_P2)) base_bit = par_prev;
        else                           base_bit = (sf_idx == SW'(SF_MHI));
      end else if (cbit_mode && sf_p1) begin
        base_bit = par_prev;
      end else if (cbit_mode && sf_p2) begin
        base_bit = 1'b1;
      end
    end
  end

  always_comb begin
    flip = 1'b0;
    if (p_slot1 && arm_q[FI_P])             flip = ~flip;
    if (p_slot2 && p_run)                   flip = ~flip;
    if (cp_first && arm_q[FI_CP])           flip = ~flip;
    if (cp_slot && !cp_first && cp_run)     flip = ~flip;
    if (fb_first && arm_q[FI_FEBE])         flip = ~flip;
    if (fb_slot && !fb_first && fb_run)     flip = ~flip;
    if (is_ovh && arm_q[FI_OE])             flip = ~flip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_bit <= 1'b0;
      line_fp  <= 1'b0;
      line_ovh <= 1'b0;
    end else begin
      line_bit <= base_bit ^ flip;
      line_fp  <= frame_start;
      line_ovh <= is_ovh;
    end
  end
endmodule

// File: rtl/ds3oi_chk.sv
module ds3oi_chk (
  input logic       clk,
  input logic       rst,
  input logic       frm_sync,
  input logic       cbit_mode,
  input logic       line_fp,
  input logic       line_ovh,
  input logic [3:0] arm_q,
  input logic [3:0] fall_w,
  input logic [3:0] use_w
);
  AST_FP_ON_OVH: assert property (@(posedge clk) disable iff (rst)
    line_fp |-> line_ovh); // R1

  AST_SYNC_FRAME: assert property (@(posedge clk) disable iff (rst)
    frm_sync |=> line_fp); // R11

  AST_P_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (arm_q[1] && use_w[1] && !fall_w[1]) |=> !arm_q[1]); // R5

  AST_OE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (arm_q[0] && use_w[0] && !fall_w[0]) |=> !arm_q[0]); // R9

  AST_CP_M13_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cbit_mode |=> !arm_q[2]); // R7

  AST_FEBE_M13_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cbit_mode |=> !arm_q[3]); // R8
endmodule

bind ds3oi_top ds3oi_chk chk_i (
  .clk(clk), .rst(rst), .frm_sync(frm_sync), .cbit_mode(cbit_mode),
  .line_fp(line_fp), .line_ovh(line_ovh),
  .arm_q(arm_q), .fall_w(fall_w), .use_w(use_w)
);

// File: tb/ds3oi_top_tb_top.sv
module ds3oi_top_tb_top;
  localparam int FBITS = 4760;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_sync = 1'b0, tx_data = 1'b0, cbit_mode = 1'b1, ovh_en = 1'b0;
  logic force_oe_n = 1'b1, force_p_n = 1'b1, force_cp_n = 1'b1, force_febe_n = 1'b1;
  logic line_bit, line_fp, line_ovh;

  always #2.5 clk = ~clk;

  ds3oi_top dut_i (
    .clk(clk), .rst(rst), .frm_sync(frm_sync), .tx_data(tx_data),
    .cbit_mode(cbit_mode), .ovh_en(ovh_en),
    .force_oe_n(force_oe_n), .force_p_n(force_p_n),
    .force_cp_n(force_cp_n), .force_febe_n(force_febe_n),
    .line_bit(line_bit), .line_fp(line_fp), .line_ovh(line_ovh)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit acc = 0, par = 0;
  bit pend_oe = 0, pend_p = 0, pend_cp = 0, pend_fb = 0;
  bit run_p = 0, run_cp = 0, run_fb = 0;
  logic [3:0] f_n = 4'hF;
  int f_hold[4] = '{0, 0, 0, 0};

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // expected output for position p with data d; updates reference state
  task automatic model(input int p, input bit d, input bit cm, output bit e, output string tag);
    int b, k, s;
    b = p % 85; k = (p / 85) % 8; s = p / 680;
    if (p == 0) begin par = acc; acc = 0; run_p = 0; run_cp = 0; run_fb = 0; end
    tag = "R1";
    if (b != 0) begin
      e = d; acc ^= d;
    end else begin
      if (k % 2 == 1) begin e = (k == 1 || k == 7); tag = "R2"; end
      else if (k == 0) begin
        if (s < 2) begin e = 1; tag = "R2"; end
        else if (s < 4) begin e = par; tag = "R3 R5"; end
        else begin e = (s == 5); tag = "R2"; end
      end else begin
        tag = "R4";
        if (cm && s == 2) begin e = par; tag = "R4 R7"; end
        else if (cm && s == 3) begin e = 1; tag = "R4 R8"; end
        else e = d;
      end
      if (k == 0 && s == 2 && pend_p) begin e = !e; run_p = 1; pend_p = 0; end
      else if (k == 0 && s == 3 && run_p) begin e = !e; run_p = 0; end
      if (cm && k != 0 && k % 2 == 0 && s == 2) begin
        if (k == 2 && pend_cp) begin e = !e; run_cp = 1; pend_cp = 0; end
        else if (k != 2 && run_cp) e = !e;
        if (k == 6) run_cp = 0;
      end
      if (cm && k != 0 && k % 2 == 0 && s == 3) begin
        if (k == 2 && pend_fb) begin e = !e; run_fb = 1; pend_fb = 0; end
        else if (k != 2 && run_fb) e = !e;
        if (k == 6) run_fb = 0;
      end
      if (pend_oe) begin e = !e; pend_oe = 0; tag = {tag, " R6"}; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit pv_e, pv_fp, pv_ov, have, e, d, sy, oe;
    string pv_tag, tg;
    int p, fr;
    logic [3:0] nf;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    check(line_bit, 1'b0, "R10", "line_bit in reset");
    check(line_fp,  1'b0, "R10", "line_fp in reset");
    check(line_ovh, 1'b0, "R10", "line_ovh in reset");
    rst = 1'b0;
    have = 0; p = 0; fr = 0;
    while (fr < 20) begin
      @(negedge clk);
      if (have) begin
        check(line_bit, pv_e, pv_tag, "line_bit");
        check(line_fp,  pv_fp, "R1 R11", "line_fp");
        check(line_ovh, pv_ov, "R1", "line_ovh");
      end
      // stimulus
      sy = (fr == 0 && p == 0);
      if (fr == 18 && p == 3000) begin sy = 1; p = 0; fr = 19; end // R11 realign
      if (p == 0) cbit_mode = (fr < 14);
      d = 1'($urandom);
      nf = f_n;
      oe = ovh_en;
      if (fr >= 2 && fr <= 7 || fr == 15 || fr == 16) begin
        if (p == 0) oe = (fr != 4);
        if (p == 50) begin
          case (fr)
            2: nf[1] = 0;              // R5
            3, 4: nf[0] = 0;           // R6
            5, 15: nf[2] = 0;          // R7
            6, 16: nf[3] = 0;          // R8
            7: nf = 4'h0;              // R9: held low across many targets
            default: ;
          endcase
        end
        if (p == 4700) nf = 4'hF;
      end else if (fr >= 8) begin
        oe = ($urandom % 4) != 0;
        for (int i = 0; i < 4; i++) begin
          if (f_hold[i] > 0) begin
            f_hold[i]--;
            if (f_hold[i] == 0) nf[i] = 1;
          end else if (nf[i] && ($urandom % 3000) == 0) begin
            nf[i] = 0; f_hold[i] = 1 + $urandom % 900;
          end
        end
      end
      frm_sync = sy; tx_data = d; ovh_en = oe;
      force_oe_n = nf[0]; force_p_n = nf[1]; force_cp_n = nf[2]; force_febe_n = nf[3];
      model(p, d, cbit_mode, e, tg);
      // arming after this bit, mirroring a falling edge seen this cycle
      if (f_n[0] && !nf[0] && oe) pend_oe = 1;
      if (f_n[1] && !nf[1]) pend_p = 1;
      if (f_n[2] && !nf[2] && cbit_mode) pend_cp = 1;
      if (f_n[3] && !nf[3] && cbit_mode) pend_fb = 1;
      if (!cbit_mode) begin pend_cp = 0; pend_fb = 0; end
      f_n = nf;
      pv_e = e; pv_tag = tg; pv_fp = (p == 0); pv_ov = (p % 85 == 0); have = 1;
      p++;
      if (p == FBITS) begin p = 0; fr++; end
    end
    @(negedge clk);
    check(line_bit, pv_e, pv_tag, "line_bit");
    check(line_fp, pv_fp, "R1 R11", "line_fp");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule